// File: doc/BRIEF.md
# ADC Offset Compensation Calibrator

This block measures the offset of a successive-approximation converter and corrects its readings. A calibration run starts with a one-cycle `start_i` request. The calibrator raises `busy_o`, and the converter holds this signal as its compensation-mode request, which forces the analog input to half of the reference. The calibrator first waits a settle interval. It then takes exactly sixteen channel-0 results, one for each `smp_valid_i` strobe, and each strobe marks a fresh conversion. It sums the results, divides the sum by sixteen with a right shift by four, and subtracts the average from the ideal mid-scale code (512 for 10-bit data). The resulting signed compensation value appears on `cv_o` and stays there until the next run completes.

The run is a four-state machine:

- **IDLE**: the machine waits here. `start_i` moves it to **SETTLE**.
- **SETTLE**: the machine counts `SETTLE_CYC` cycles and ignores all strobes. When the count expires it moves to **SAMPLE**.
- **SAMPLE**: the machine accepts strobes. The sixteenth accepted strobe moves it to **FINISH**.
- **FINISH**: the machine latches the new value, raises `done_o` and returns to **IDLE**.

The block also has a correction path. A channel reading presented on `rd_valid_i` is returned one cycle later with its offset and with the corrected sum. If battery sensing is enabled and the reading comes from the battery channel, the reading and the offset are both scaled by a gain of 3/1 or 3/2, chosen by a divider-select bit. A trim pass-through replaces a zero trim value with the default value 8.

Top module: `adc_offset_cal`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `done_o` and `corr_valid_o` are 0 and `cv_o` is 0.
- R2: A `start_i` seen at a clock edge while IDLE moves the machine to SETTLE, and `busy_o` is 1 from the next cycle until the cycle in which `done_o` is 1.
- R3: SETTLE lasts exactly `SETTLE_CYC` clock edges, and strobes at any of those edges are not accumulated. The first strobe that can count is the one at the edge after the last SETTLE edge.
- R4: In SAMPLE, each edge with `smp_valid_i` high accepts one 10-bit result. After the sixteenth accepted result the machine spends one cycle in FINISH. At the next edge `done_o` goes to 1 and `busy_o` goes to 0.
- R5: `cv_o` is an 11-bit two's-complement value equal to 512 − (sum of the 16 results >> 4), with a range of −511 to +512. It updates at the same edge at which `done_o` rises.
- R6: `done_o` is high for exactly one cycle per completed run.
- R7: `cv_o` holds its value from one completion to the next. Strobes outside a run change neither `cv_o` nor `busy_o`.
- R8: A `start_i` while `busy_o` is 1 is ignored: the sample count is not disturbed and the run completes with the result of its own samples.
- R9: An edge with `rd_valid_i` high produces, one cycle later, `corr_valid_o` = 1 together with `corr_raw_o`, `corr_off_o` and `corr_sum_o` = `corr_raw_o` + `corr_off_o`. `corr_valid_o` is 0 in the cycle after an edge without `rd_valid_i`. A reading that is not a battery reading is passed through with `corr_off_o` = `cv_o`.
- R10: A reading is a battery reading when `bat_en_i` is 1 and `rd_chan_i` equals 7. For such a reading, the reading and the offset are each multiplied by 3, and are divided by 1 when `div_sel_i` is 1 or by 2 when it is 0. The division truncates toward zero.
- R11: `trim_o` equals `trim_i`, except that `trim_i` = 0 gives `trim_o` = 8. The mapping is combinational.
- R12: The accumulator is 14 bits wide and never wraps, even with sixteen results of 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Calibration request |
| busy_o | output | 1 | Run in progress; also the converter's compensation-mode request |
| done_o | output | 1 | One-cycle completion pulse |
| smp_valid_i | input | 1 | Fresh channel-0 result strobe |
| smp_data_i | input | 10 | Channel-0 result |
| cv_o | output | 11 | Signed compensation value |
| trim_i | input | 4 | Supplied trim value |
| trim_o | output | 4 | Trim value with zero replaced by 8 |
| rd_valid_i | input | 1 | Reading to correct is present |
| rd_chan_i | input | 4 | Channel number of the reading |
| rd_data_i | input | 10 | Raw reading |
| bat_en_i | input | 1 | Battery sensing enabled |
| div_sel_i | input | 1 | Battery divider select: 1 gives gain 3/1, 0 gives gain 3/2 |
| corr_valid_o | output | 1 | Corrected outputs valid |
| corr_raw_o | output | 12 | Reading, scaled if it is a battery reading |
| corr_off_o | output | 13 | Signed offset, scaled if it is a battery reading |
| corr_sum_o | output | 14 | Signed sum of the reading and the offset |

## Verification
After the `start_i` edge, `busy_o` is due one cycle later. The bench then strobes garbage data at every one of the `SETTLE_CYC` settle edges and puts the first real sample on the edge that follows them. Any error in the settle length therefore either counts garbage or loses a sample, and the run result or the completion timing shows it. The final strobe is followed by one FINISH cycle. The bench checks that `done_o` is still low one cycle after that strobe, that `done_o` and the new `cv_o` are present two cycles after it, and that `done_o` is low again in the third. Correction outputs are sampled one cycle after `rd_valid_i`, and `trim_o` is sampled shortly after a change of `trim_i`. Every sample is taken at a falling clock edge.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE   = 2'd0,
        CAL_SETTLE = 2'd1,
        CAL_SAMPLE = 2'd2,
        CAL_FINISH = 2'd3
    } cal_state_e;

endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
    parameter int SETTLE_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired_o = run_i && (cnt_q == CNT_W'(SETTLE_CYC - 1));

endmodule

// File: rtl/cal_accum.sv
module cal_accum #(
    parameter int DATA_W   = 10,
    parameter int SMP_LOG2 = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         add_i,
    input  logic [DATA_W-1:0]            data_i,
    output logic [DATA_W+SMP_LOG2-1:0]   sum_o,
    output logic                         last_o
);
    localparam int ACC_W = DATA_W + SMP_LOG2;

    logic [ACC_W-1:0]    sum_q;
    logic [SMP_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (add_i) begin
            sum_q <= sum_q + ACC_W'(data_i);
            cnt_q <= cnt_q + SMP_LOG2'(1);
        end
    end

    assign sum_o  = sum_q;
    assign last_o = add_i && (cnt_q == '1);

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !clear_i) |=> (sum_q >= $past(sum_q)));

endmodule

// File: rtl/cal_correct.sv
module cal_correct #(
    parameter int DATA_W = 10,
    parameter int CH_W   = 4,
    parameter int BAT_CH = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [DATA_W:0]     cv_i,
    input  logic                       rd_valid_i,
    input  logic [CH_W-1:0]            rd_chan_i,
    input  logic [DATA_W-1:0]          rd_data_i,
    input  logic                       bat_en_i,
    input  logic                       div_sel_i,
    output logic                       corr_valid_o,
    output logic [DATA_W+1:0]          corr_raw_o,
    output logic signed [DATA_W+2:0]   corr_off_o,
    output logic signed [DATA_W+3:0]   corr_sum_o
);
    localparam int RAW_W = DATA_W + 2;
    localparam int OFF_W = DATA_W + 3;
    localparam int SUM_W = DATA_W + 4;

    logic                    is_bat;
    logic [RAW_W-1:0]        raw3, raw_s;
    logic signed [OFF_W-1:0] cv_ext, off3, off3_half, off_s;
    logic signed [SUM_W-1:0] sum_s;

    always_comb begin
        is_bat    = bat_en_i && (rd_chan_i == CH_W'(BAT_CH));
        raw3      = {2'b00, rd_data_i} + {1'b0, rd_data_i, 1'b0};
        cv_ext    = {{2{cv_i[DATA_W]}}, cv_i};
        off3      = cv_ext + $signed({cv_ext[OFF_W-2:0], 1'b0});
        off3_half = (off3 + $signed({{(OFF_W-1){1'b0}}, off3[OFF_W-1]})) >>> 1;
        if (is_bat) begin
            raw_s = div_sel_i ? raw3 : (raw3 >> 1);
            off_s = div_sel_i ? off3 : off3_half;
        end else begin
            raw_s = {2'b00, rd_data_i};
            off_s = cv_ext;
        end
        sum_s = $signed({{(SUM_W-RAW_W){1'b0}}, raw_s}) + $signed({off_s[OFF_W-1], off_s});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_valid_o <= 1'b0;
            corr_raw_o   <= '0;
            corr_off_o   <= '0;
            corr_sum_o   <= '0;
        end else begin
            corr_valid_o <= rd_valid_i;
            if (rd_valid_i) begin
                corr_raw_o <= raw_s;
                corr_off_o <= off_s;
                corr_sum_o <= sum_s;
            end
        end
    end

    // R9
    corr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_i |=> corr_valid_o);

    // R9
    corr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && !(bat_en_i && rd_chan_i == CH_W'(BAT_CH)))
        |=> (corr_raw_o == RAW_W'($past(rd_data_i))));

endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal #(
    parameter int DATA_W     = 10,
    parameter int SMP_LOG2   = 4,
    parameter int SETTLE_CYC = 250000,
    parameter int CH_W       = 4,
    parameter int BAT_CH     = 7,
    parameter int TRIM_W     = 4,
    parameter int TRIM_DEF   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    output logic                       busy_o,
    output logic                       done_o,
    input  logic                       smp_valid_i,
    input  logic [DATA_W-1:0]          smp_data_i,
    output logic signed [DATA_W:0]     cv_o,
    input  logic [TRIM_W-1:0]          trim_i,
    output logic [TRIM_W-1:0]          trim_o,
    input  logic                       rd_valid_i,
    input  logic [CH_W-1:0]            rd_chan_i,
    input  logic [DATA_W-1:0]          rd_data_i,
    input  logic                       bat_en_i,
    input  logic                       div_sel_i,
    output logic                       corr_valid_o,
    output logic [DATA_W+1:0]          corr_raw_o,
    output logic signed [DATA_W+2:0]   corr_off_o,
    output logic signed [DATA_W+3:0]   corr_sum_o
);
    import cal_pkg::*;

    localparam int                ACC_W    = DATA_W + SMP_LOG2;
    localparam int                CV_W     = DATA_W + 1;
    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    cal_state_e              state_q, state_d;
    logic                    clear_run, settle_done, acc_add, acc_last;
    logic [ACC_W-1:0]        acc_sum;
    logic [DATA_W-1:0]       avg;
    logic signed [CV_W-1:0]  cv_calc, cv_q;
    logic                    done_q;

    assign clear_run = (state_q == CAL_IDLE) && start_i;
    assign acc_add   = (state_q == CAL_SAMPLE) && smp_valid_i;

    cal_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_run),
        .run_i     (state_q == CAL_SETTLE),
        .expired_o (settle_done)
    );

    cal_accum #(.DATA_W(DATA_W), .SMP_LOG2(SMP_LOG2)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_run),
        .add_i   (acc_add),
        .data_i  (smp_data_i),
        .sum_o   (acc_sum),
        .last_o  (acc_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAL_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE:   if (start_i)     state_d = CAL_SETTLE;
            CAL_SETTLE: if (settle_done) state_d = CAL_SAMPLE;
            CAL_SAMPLE: if (acc_last)    state_d = CAL_FINISH;
            CAL_FINISH:                  state_d = CAL_IDLE;
        endcase
    end

    assign avg     = acc_sum[ACC_W-1:SMP_LOG2];
    assign cv_calc = $signed({1'b0, MID_CODE}) - $signed({1'b0, avg});

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            cv_q   <= '0;
        end else begin
            done_q <= (state_q == CAL_FINISH);
            if (state_q == CAL_FINISH) cv_q <= cv_calc;
        end
    end

    assign busy_o = (state_q != CAL_IDLE);
    assign done_o = done_q;
    assign cv_o   = cv_q;
    assign trim_o = (trim_i == '0) ? TRIM_W'(TRIM_DEF) : trim_i;

    cal_correct #(.DATA_W(DATA_W), .CH_W(CH_W), .BAT_CH(BAT_CH)) u_correct (
        .clk          (clk),
        .rst_n        (rst_n),
        .cv_i         (cv_q),
        .rd_valid_i   (rd_valid_i),
        .rd_chan_i    (rd_chan_i),
        .rd_data_i    (rd_data_i),
        .bat_en_i     (bat_en_i),
        .div_sel_i    (div_sel_i),
        .corr_valid_o (corr_valid_o),
        .corr_raw_o   (corr_raw_o),
        .corr_off_o   (corr_off_o),
        .corr_sum_o   (corr_sum_o)
    );

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_IDLE && start_i) |=> busy_o);

    // R3
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_SETTLE) |-> (acc_sum == '0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_q != $past(cv_q)) |-> done_q);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_SAMPLE && start_i && !smp_valid_i) |=> (state_q == CAL_SAMPLE));

    // R11
    always_comb begin
        if (!$isunknown(trim_i)) begin
            trim_nonzero_chk: assert (trim_o != '0);
        end
    end

endmodule

// File: tb/tb_adc_offset_cal.sv
`timescale 1ns/1ps
module tb_adc_offset_cal;
    localparam int SETTLE = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic smp_valid_i = 1'b0;
    logic [9:0] smp_data_i = '0;
    logic [3:0] trim_i = 4'd3;
    logic rd_valid_i = 1'b0;
    logic [3:0] rd_chan_i = '0;
    logic [9:0] rd_data_i = '0;
    logic bat_en_i = 1'b0;
    logic div_sel_i = 1'b0;
    logic busy_o, done_o, corr_valid_o;
    logic signed [10:0] cv_o;
    logic [3:0] trim_o;
    logic [11:0] corr_raw_o;
    logic signed [12:0] corr_off_o;
    logic signed [13:0] corr_sum_o;

    int n_tests = 0;
    int n_fail = 0;
    int cur_cv = 0;

    always #2 clk = ~clk;

    adc_offset_cal #(.SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .cv_o(cv_o),
        .trim_i(trim_i), .trim_o(trim_o), .rd_valid_i(rd_valid_i), .rd_chan_i(rd_chan_i),
        .rd_data_i(rd_data_i), .bat_en_i(bat_en_i), .div_sel_i(div_sel_i),
        .corr_valid_o(corr_valid_o), .corr_raw_o(corr_raw_o), .corr_off_o(corr_off_o),
        .corr_sum_o(corr_sum_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    function automatic int sample_val(input int pat, input int i);
        case (pat)
            0: return 512;
            1: return 0;
            2: return 1023;
            3: return 500 + i;
            4: return 520 + (i % 2);
            default: return 517;
        endcase
    endfunction

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 cv", int'(cv_o), 0);
        chk("R1 corr_valid", int'(corr_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", int'(busy_o), 0);
    endtask

    task automatic run_cal(input int pat, input bit poke_start);
        int sum = 0;
        int exp_cv;
        for (int i = 0; i < 16; i++) sum += sample_val(pat, i);
        exp_cv = 512 - (sum >> 4);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 busy after start", int'(busy_o), 1);
        // garbage strobes on every settle edge must be dropped (R3)
        smp_valid_i = 1'b1;
        smp_data_i = 10'd1023;
        repeat (SETTLE) @(negedge clk);
        chk("R3 still busy after settle", int'(busy_o), 1);
        for (int i = 0; i < 16; i++) begin
            smp_valid_i = 1'b1;
            smp_data_i = 10'(sample_val(pat, i));
            @(negedge clk);
            smp_valid_i = 1'b0;
            smp_data_i = 10'd1023;
            if (i < 15) begin
                if (poke_start && i == 8) start_i = 1'b1; // R8
                @(negedge clk);
                start_i = 1'b0;
                @(negedge clk);
            end
        end
        chk("R4 done not yet", int'(done_o), 0);
        chk("R4 busy in finish", int'(busy_o), 1);
        @(negedge clk);
        chk("R4 done", int'(done_o), 1);
        chk("R4 busy low", int'(busy_o), 0);
        chk(poke_start ? "R8 cv" : "R5 cv", int'(cv_o), exp_cv);
        @(negedge clk);
        chk("R6 done single", int'(done_o), 0);
        chk("R7 cv held", int'(cv_o), exp_cv);
        cur_cv = exp_cv;
    endtask

    task automatic test_hold;
        for (int i = 0; i < 5; i++) begin
            smp_valid_i = 1'b1;
            smp_data_i = 10'(i * 100);
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
        @(negedge clk);
        chk("R7 busy idle strobes", int'(busy_o), 0);
        chk("R7 cv after idle strobes", int'(cv_o), cur_cv);
    endtask

    task automatic corr_case(input int ch, input int data, input bit bat, input bit dsel);
        bit is_bat = bat && (ch == 7);
        int exp_raw, exp_off;
        if (is_bat) begin
            exp_raw = dsel ? data * 3 : (data * 3) / 2;
            exp_off = dsel ? cur_cv * 3 : (cur_cv * 3) / 2;
        end else begin
            exp_raw = data;
            exp_off = cur_cv;
        end
        rd_valid_i = 1'b1;
        rd_chan_i = 4'(ch);
        rd_data_i = 10'(data);
        bat_en_i = bat;
        div_sel_i = dsel;
        @(negedge clk);
        rd_valid_i = 1'b0;
        chk("R9 corr_valid", int'(corr_valid_o), 1);
        chk(is_bat ? "R10 raw" : "R9 raw", int'(corr_raw_o), exp_raw);
        chk(is_bat ? "R10 off" : "R9 off", int'(corr_off_o), exp_off);
        chk("R9 sum", int'(corr_sum_o), exp_raw + exp_off);
        @(negedge clk);
        chk("R9 corr_valid drop", int'(corr_valid_o), 0);
    endtask

    task automatic test_trim;
        trim_i = 4'd0;
        #1 chk("R11 zero trim", int'(trim_o), 8);
        trim_i = 4'd5;
        #1 chk("R11 pass trim", int'(trim_o), 5);
        trim_i = 4'd15;
        #1 chk("R11 max trim", int'(trim_o), 15);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        test_reset();
        run_cal(0, 1'b0);   // cv 0
        run_cal(1, 1'b0);   // cv 512
        run_cal(2, 1'b0);   // cv -511, full-scale sum (R12)
        run_cal(3, 1'b0);   // cv 5, truncated average
        test_hold();
        run_cal(4, 1'b1);   // cv -8 with start while busy
        run_cal(5, 1'b0);   // cv -5
        corr_case(3, 101, 1'b0, 1'b0);
        corr_case(7, 101, 1'b0, 1'b1);
        corr_case(3, 101, 1'b1, 1'b1);
        corr_case(7, 101, 1'b1, 1'b1);
        corr_case(7, 101, 1'b1, 1'b0);
        corr_case(7, 1023, 1'b1, 1'b0);
        run_cal(1, 1'b0);   // cv 512
        corr_case(7, 1023, 1'b1, 1'b1);
        test_trim();
        summary();
    end

endmodule